// File: doc/BRIEF.md
# QPSK carrier recovery loop

This block recovers the carrier phase of a real QPSK sample stream taken at four times the nominal carrier rate (for example 50 MHz samples of a 12.5 MHz carrier). A numerically controlled oscillator produces a cosine reference and a negated sine reference. Each one is multiplied with the incoming sample, and each product is smoothed by a 15-tap triangular low-pass filter. The two filters give the in-phase arm X and the quadrature arm Y.

The sign bits of the two arms are taken as hard decisions. A cross-product detector forms the phase error Y·sign(X) − X·sign(Y). This error drives a proportional-plus-integral filter, and the filter's output is added to the oscillator's nominal phase increment. Once the loop settles, the constellation points sit on the diagonals of the X/Y plane. The absolute rotation is known only to a multiple of 90°, so the block is meant to be followed by a differential decoder.

A lock indicator averages the absolute phase error over fixed windows of 256 samples and compares the average with a threshold set at an input pin.

Top module: `qpsk_carrier_rec`

## Requirements
- R1: While rst_ni is low, i_o and q_o are zero, both decision outputs are 0 and lock_o is low.
- R2: For an input carrier at exactly a quarter of the sample rate, with any of the four symbol phases and an amplitude from 1000 to 1800, the following hold within 12000 samples: lock_o is high, |i_o| exceeds a quarter of the input amplitude, and |i_o| and |q_o| differ by at most 80.
- R3: For a carrier offset of up to ±1 kHz at a 50 MHz sample rate, the same conditions as in R2 hold. The loop integrator saturates at its limits and never wraps.
- R4: dec_i_o is 1 when i_o is negative and 0 when i_o is zero or positive. dec_q_o follows the same rule for q_o.
- R5: Quadrants are numbered 0 = (+,+), 1 = (−,+), 2 = (−,−), 3 = (+,−) on (I,Q). The transmitted symbol phase is 45° + 90°·k. Across symbol changes while tracking, the decided quadrant minus the transmitted k, taken modulo 4, stays constant.
- R6: lock_o changes only at the end of each 256-sample window counted from reset release, so it stays low for the first 255 samples.
- R7: At a window end, lock_o is set when the window's mean |phase error| is strictly below lock_thr_i. With a threshold of 0 it never sets. A zero input gives zero arms and zero error.
- R8: lock_o clears at the first window end at which the mean |phase error| is not below lock_thr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 12 | Received real sample, signed |
| lock_thr_i | input | 16 | Lock threshold on the mean absolute phase error |
| i_o | output | 16 | Filtered in-phase arm, signed |
| q_o | output | 16 | Filtered quadrature arm, signed |
| dec_i_o | output | 1 | In-phase decision, 1 means negative |
| dec_q_o | output | 1 | Quadrature decision, 1 means negative |
| lock_o | output | 1 | Lock indicator |

## Verification
The loop is driven with clean carriers in several ways:
- At every symbol phase, to show that it settles on the nearest diagonal, whichever quadrant it starts in.
- At +1 kHz, −1 kHz and −700 Hz offsets, to separate a working integrator from a proportional-only loop, which would leave a standing phase error and unbalanced arms.
- With a zero input, which gives a deterministic all-zero error and so pins down the window timing, the strict comparison and the clearing rule of the lock detector.
- With a sequence of symbols that mixes 90° and 180° steps, to show that the residual rotation stays fixed across symbol changes.

// File: rtl/qpsk_cr_pkg.sv
package qpsk_cr_pkg;
  localparam int N_ARMS = 2;
  typedef enum logic {DEC_POS = 1'b0, DEC_NEG = 1'b1} dec_e;
endpackage

// File: rtl/cr_nco.sv
module cr_nco #(
  parameter int PH_W   = 32,
  parameter int LUT_AW = 8,
  parameter int REF_W  = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PH_W-1:0]         fw_i,
  output logic signed [REF_W-1:0] cos_o,
  output logic signed [REF_W-1:0] nsin_o
);
  localparam int LUT_N = 1 << LUT_AW;
  localparam int AMP   = (1 << (REF_W-1)) - 1;
  localparam logic [PH_W-1:0] QTR = PH_W'(1) << (PH_W-2);

  // quarter-wave magnitudes, sampled half a step off the axis
  logic [REF_W-2:0] lut [LUT_N];
  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    localparam real ANG = (real'(g) + 0.5) * 3.141592653589793 / (2.0 * real'(LUT_N));
    localparam int  VAL = $rtoi(real'(AMP) * $sin(ANG) + 0.5);
    assign lut[g] = VAL[REF_W-2:0];
  end

  logic [PH_W-1:0] ph_q;

  function automatic logic signed [REF_W-1:0] sin_of(input logic [PH_W-1:0] p);
    logic [1:0]        qd;
    logic [LUT_AW-1:0] ix;
    logic [REF_W-2:0]  mag;
    qd  = p[PH_W-1 -: 2];
    ix  = p[PH_W-3 -: LUT_AW];
    mag = qd[0] ? lut[~ix] : lut[ix];
    return qd[1] ? -signed'({1'b0, mag}) : signed'({1'b0, mag});
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      cos_o  <= '0;
      nsin_o <= '0;
    end else begin
      ph_q   <= ph_q + fw_i;
      cos_o  <= sin_of(ph_q + QTR);
      nsin_o <= -sin_of(ph_q);
    end
  end
endmodule

// File: rtl/cr_arm.sv
module cr_arm #(
  parameter int IN_W  = 12,
  parameter int REF_W = 12,
  parameter int TAPS  = 15,
  parameter int ARM_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  sample_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic signed [ARM_W-1:0] arm_o
);
  localparam int MIX_W  = IN_W + 1;
  localparam int PROD_W = IN_W + REF_W;
  localparam int HALF   = (TAPS + 1) / 2;
  localparam int CSH    = $clog2(HALF * HALF);
  localparam int SUM_W  = MIX_W + CSH + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [MIX_W-1:0]  mix_q;
  logic signed [MIX_W-1:0]  tap_q [TAPS];
  logic signed [SUM_W-1:0]  acc;

  function automatic int coef(input int k);
    return (k < TAPS - k) ? k + 1 : TAPS - k;
  endfunction

  assign prod = PROD_W'(sample_i) * PROD_W'(ref_i);

  // triangular taps: unity DC gain, null at half the sample rate
  always_comb begin
    logic signed [SUM_W-1:0] cf;
    acc = '0;
    for (int k = 0; k < TAPS; k++) begin
      cf  = SUM_W'(coef(k));
      acc = acc + cf * SUM_W'(tap_q[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mix_q <= '0;
      for (int k = 0; k < TAPS; k++) tap_q[k] <= '0;
      arm_o <= '0;
    end else begin
      mix_q    <= MIX_W'(prod >>> (REF_W - 1));
      tap_q[0] <= mix_q;
      for (int k = 1; k < TAPS; k++) tap_q[k] <= tap_q[k-1];
      arm_o    <= ARM_W'(acc >>> CSH);
    end
  end
endmodule

// File: rtl/cr_loop_filt.sv
module cr_loop_filt #(
  parameter int ARM_W = 16,
  parameter int PH_W  = 32,
  parameter int KP_SH = 14,
  parameter int KI_SH = 6,
  parameter int INT_W = 28
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [ARM_W-1:0]  x_i,
  input  logic signed [ARM_W-1:0]  y_i,
  output logic signed [ARM_W+1:0]  err_o,
  output logic signed [PH_W-1:0]   ctrl_o
);
  localparam int ERR_W = ARM_W + 2;
  localparam logic signed [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic signed [INT_W:0]   HI = (INT_W+1)'(INT_MAX);
  localparam logic signed [INT_W:0]   LO = (INT_W+1)'(INT_MIN);

  logic signed [ERR_W-1:0] xe, ye, err_d, err_q;
  logic signed [INT_W-1:0] integ_q, inc;
  logic signed [INT_W:0]   isum;

  always_comb begin
    xe    = ERR_W'(x_i);
    ye    = ERR_W'(y_i);
    err_d = (x_i[ARM_W-1] ? -ye : ye) - (y_i[ARM_W-1] ? -xe : xe);
    inc   = INT_W'(err_q) <<< KI_SH;
    isum  = (INT_W+1)'(integ_q) + (INT_W+1)'(inc);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      integ_q <= '0;
      ctrl_o  <= '0;
    end else begin
      err_q   <= err_d;
      if (isum > HI)      integ_q <= INT_MAX;
      else if (isum < LO) integ_q <= INT_MIN;
      else                integ_q <= INT_W'(isum);
      ctrl_o  <= (PH_W'(err_q) <<< KP_SH) + PH_W'(integ_q);
    end
  end

  assign err_o = err_q;

  // R7
  zero_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i == '0 && y_i == '0) |=> err_q == '0);
  // R3
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integ_q == INT_MAX && inc >= 0) |=> integ_q == INT_MAX);
  // R3
  sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integ_q == INT_MIN && inc <= 0) |=> integ_q == INT_MIN);
endmodule

// File: rtl/cr_lock_det.sv
module cr_lock_det #(
  parameter int ERR_W = 18,
  parameter int THR_W = 16,
  parameter int LOG2  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic [THR_W-1:0]        thr_i,
  output logic                    lock_o
);
  localparam int SUM_W = ERR_W + LOG2;
  localparam int CMP_W = (ERR_W > THR_W) ? ERR_W : THR_W;

  logic [LOG2-1:0]  cnt_q;
  logic [SUM_W-1:0] sum_q, sum_d;
  logic [ERR_W-1:0] mag;
  logic             win_end;

  assign win_end = &cnt_q;
  assign mag     = err_i[ERR_W-1] ? ERR_W'(-err_i) : ERR_W'(err_i);
  assign sum_d   = sum_q + SUM_W'(mag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sum_q  <= '0;
      lock_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (win_end) begin
        sum_q  <= '0;
        lock_o <= CMP_W'(sum_d[SUM_W-1:LOG2]) < CMP_W'(thr_i);
      end else begin
        sum_q  <= sum_d;
      end
    end
  end

  // R6
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> $stable(lock_o));
  // R7
  lock_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(thr_i) != '0);
endmodule

// File: rtl/qpsk_carrier_rec.sv
module qpsk_carrier_rec
  import qpsk_cr_pkg::*;
#(
  parameter int IN_W      = 12,
  parameter int REF_W     = 12,
  parameter int LUT_AW    = 8,
  parameter int PH_W      = 32,
  parameter logic [PH_W-1:0] NOM_INC = PH_W'(1) << (PH_W-2),
  parameter int TAPS      = 15,
  parameter int ARM_W     = 16,
  parameter int KP_SH     = 14,
  parameter int KI_SH     = 6,
  parameter int INT_W     = 28,
  parameter int LOCK_LOG2 = 8,
  parameter int THR_W     = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  sample_i,
  input  logic [THR_W-1:0]        lock_thr_i,
  output logic signed [ARM_W-1:0] i_o,
  output logic signed [ARM_W-1:0] q_o,
  output logic                    dec_i_o,
  output logic                    dec_q_o,
  output logic                    lock_o
);
  localparam int ERR_W = ARM_W + 2;

  logic [PH_W-1:0]         fw;
  logic signed [PH_W-1:0]  ctrl;
  logic signed [REF_W-1:0] refs [N_ARMS];
  logic signed [ARM_W-1:0] arm  [N_ARMS];
  dec_e                    dec  [N_ARMS];
  logic signed [ERR_W-1:0] err;

  assign fw = NOM_INC + $unsigned(ctrl);

  cr_nco #(.PH_W(PH_W), .LUT_AW(LUT_AW), .REF_W(REF_W)) u_nco (
    .clk_i, .rst_ni, .fw_i(fw), .cos_o(refs[0]), .nsin_o(refs[1]));

  for (genvar g = 0; g < N_ARMS; g++) begin : g_arm
    cr_arm #(.IN_W(IN_W), .REF_W(REF_W), .TAPS(TAPS), .ARM_W(ARM_W)) u_arm (
      .clk_i, .rst_ni, .sample_i, .ref_i(refs[g]), .arm_o(arm[g]));
    assign dec[g] = arm[g][ARM_W-1] ? DEC_NEG : DEC_POS;
  end

  cr_loop_filt #(.ARM_W(ARM_W), .PH_W(PH_W), .KP_SH(KP_SH), .KI_SH(KI_SH),
                 .INT_W(INT_W)) u_lf (
    .clk_i, .rst_ni, .x_i(arm[0]), .y_i(arm[1]), .err_o(err), .ctrl_o(ctrl));

  cr_lock_det #(.ERR_W(ERR_W), .THR_W(THR_W), .LOG2(LOCK_LOG2)) u_lock (
    .clk_i, .rst_ni, .err_i(err), .thr_i(lock_thr_i), .lock_o(lock_o));

  assign i_o     = arm[0];
  assign q_o     = arm[1];
  assign dec_i_o = (dec[0] == DEC_NEG);
  assign dec_q_o = (dec[1] == DEC_NEG);

  // R4
  dec_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i_o == (i_o < 0)) && (dec_q_o == (q_o < 0)));
endmodule

// File: tb/tb_qpsk_carrier_rec.sv
`timescale 1ns/1ps
module tb_qpsk_carrier_rec;
  localparam int  IN_W  = 12;
  localparam int  ARM_W = 16;
  localparam real PI    = 3.141592653589793;
  localparam real FS    = 50.0e6;
  localparam real FC    = 12.5e6;
  localparam int  NV    = 6;
  localparam int  VOFF [NV] = '{0, 1000, -1000, 0, -700, 1000};
  localparam int  VQD  [NV] = '{0, 1, 2, 3, 2, 0};
  localparam int  VAMP [NV] = '{1500, 1500, 1500, 1000, 1800, 1200};
  localparam int  NS = 8;
  localparam int  SEQ [NS] = '{1, 3, 2, 2, 0, 3, 1, 0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [IN_W-1:0]  sample_i = '0;
  logic [15:0]             lock_thr_i = 16'd1;
  logic signed [ARM_W-1:0] i_o, q_o;
  logic dec_i_o, dec_q_o, lock_o;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  real ph = 0.0;

  always #2.5 clk = ~clk;

  qpsk_carrier_rec dut (.clk_i(clk), .rst_ni, .sample_i, .lock_thr_i,
                        .i_o, .q_o, .dec_i_o, .dec_q_o, .lock_o);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int n, input int off_hz, input int quad, input int amp);
    real v;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ph = ph + 2.0 * PI * (FC + real'(off_hz)) / FS;
      if (ph > 2.0 * PI) ph = ph - 2.0 * PI;
      v = real'(amp) * $cos(ph + PI / 4.0 + real'(quad) * PI / 2.0);
      sample_i = IN_W'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  function automatic int iabs(input int x);
    return x < 0 ? -x : x;
  endfunction

  function automatic int quad_of(input logic di, input logic dq);
    case ({di, dq})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  initial begin
    int ai, aq, rot0, rot;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(i_o == 0 && q_o == 0, "R1 arms in reset", int'(i_o), 0);
    chk(!dec_i_o && !dec_q_o, "R1 decisions in reset", {dec_i_o, dec_q_o}, 0);
    chk(!lock_o, "R1 lock in reset", lock_o, 0);

    // zero input: window timing, strict threshold, clearing
    @(negedge clk) rst_ni = 1'b1;
    repeat (200) @(negedge clk);
    chk(!lock_o, "R6 lock before first window end", lock_o, 0);
    repeat (100) @(negedge clk);
    chk(lock_o, "R7 lock with zero error and threshold 1", lock_o, 1);
    chk(i_o == 0 && q_o == 0, "R7 zero input gives zero arms", int'(i_o), 0);
    chk(!dec_i_o && !dec_q_o, "R4 zero arm decides positive", {dec_i_o, dec_q_o}, 0);
    lock_thr_i = 16'd0;
    repeat (300) @(negedge clk);
    chk(!lock_o, "R8 lock clears when mean not below threshold", lock_o, 0);
    run(8000, 0, 0, 1500);
    chk(!lock_o, "R7 threshold 0 never locks", lock_o, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      lock_thr_i = 16'd40;
      do_reset();
      run(12000, VOFF[v], VQD[v], VAMP[v]);
      ai = iabs(int'(i_o));
      aq = iabs(int'(q_o));
      if (VOFF[v] == 0) begin
        chk(lock_o, "R2 lock on nominal carrier", lock_o, 1);
        chk(iabs(ai - aq) <= 80 && ai > VAMP[v] / 4, "R2 arms balanced", ai - aq, 0);
      end else begin
        chk(lock_o, "R3 lock with offset", lock_o, 1);
        chk(iabs(ai - aq) <= 80 && ai > VAMP[v] / 4, "R3 arms balanced with offset", ai - aq, 0);
      end
      chk(dec_i_o == (i_o < 0) && dec_q_o == (q_o < 0), "R4 decision signs",
          {dec_i_o, dec_q_o}, {i_o < 0, q_o < 0});
    end

    // R5 rotation stays constant across symbol changes
    lock_thr_i = 16'd40;
    do_reset();
    run(10000, 0, 0, 1500);
    rot0 = (quad_of(dec_i_o, dec_q_o) + 4) % 4;
    for (int s = 0; s < NS; s++) begin
      run(600, 0, SEQ[s], 1500);
      rot = (quad_of(dec_i_o, dec_q_o) - SEQ[s] + 4) % 4;
      chk(rot == rot0, "R5 constant quadrant rotation", rot, rot0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule